// File: doc/BRIEF.md
# Synchronized Even-Ratio Clock Output Channel

This block is one output lane of a clock distribution tree. It runs on the distribution clock and produces one logic-level clock. A 2-bit path selector chooses between two sources. The first is the distribution clock passed straight through. The second is an internal even-ratio divider whose ratio is twice an 8-bit code. A 4-bit delay code is carried alongside as a tag for an analog delay stage outside this block. The tag reads zero whenever the selected path does not include delay.

Several lanes share one active-low synchronization input. Pulling it low forces every divided lane low after a fixed latency. Releasing it restarts every divider from the same phase, so that all divided lanes rise on the same distribution-clock edge. Lanes on the pass-through paths ignore the synchronization input. Each lane has its own enable bit. That bit is ANDed with a shared global enable bit and a shared global enable pin. A lane that is not enabled drives a constant 0.

Configuration is loaded as a single word through a one-cycle write strobe.

Top module: `clk_chan_div`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the lane is disabled, `clk_out` is 0, `mode_o` is 0 (bypass) and `dly_tag` is 0.
- R2: When `cfg_wr` is 1 at a rising edge, the enable, path, divide code and delay code are loaded at that edge, and `mode_o` shows the new path code after it.
- R3: In path codes 1 (divided) and 3 (divided and delayed), the output period is 2×code distribution-clock cycles. After a synchronization release, the output is high for the first code cycles and then low for code cycles.
- R4: A divide code of 0 behaves exactly like code 1, which gives divide-by-2.
- R5: If `sync_n` is first sampled low at edge k and stays low, divided outputs are low from edge k+4 onward, for as long as the low lasts.
- R6: If `sync_n` is first sampled high again at edge m, every divided output goes high at edge m+4. Lanes with the same code then stay in phase.
- R7: In path codes 0 (bypass) and 2 (delayed), `clk_out` follows the distribution clock and is not affected by `sync_n`.
- R8: `clk_out` is 0 unless the lane's enable bit, `gbl_en_bit` and `gbl_en_pin` are all 1.
- R9: `dly_tag` equals the stored delay code in path codes 2 and 3, and is 0 in path codes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Distribution clock |
| rst_n | input | 1 | Active-low reset |
| sync_n | input | 1 | Shared active-low synchronization request (asynchronous) |
| gbl_en_pin | input | 1 | Shared global enable pin |
| gbl_en_bit | input | 1 | Shared global enable bit |
| cfg_wr | input | 1 | One-cycle configuration load strobe |
| cfg_en | input | 1 | Lane enable bit to load |
| cfg_mode | input | 2 | Path code to load: 0 bypass, 1 divided, 2 delayed, 3 divided and delayed |
| cfg_div | input | CODE_W | Divide code to load (ratio = 2×code, 0 treated as 1) |
| cfg_dly | input | DLY_W | Delay code to load |
| clk_out | output | 1 | Lane clock output |
| mode_o | output | 2 | Current path code |
| dly_tag | output | DLY_W | Delay code for the external delay stage, 0 when the path has no delay |

## Verification
On every cycle, the checker covers four things. It checks that a low global enable silences the lane and that a configuration write shows up on the path code. It checks that a divided output stays low once the synchronization input has been low for five samples. It also checks that a divide-by-2 lane toggles on every edge in steady state. Only the bench scenarios can show the exact four-edge latencies on assertion and release, the phase at which each ratio restarts, and the common rising edge of several lanes. The same holds for the pass-through lanes continuing through a synchronization pulse and for the code-0 fallback.

// File: rtl/clk_chan_div.sv
module clk_chan_div #(
  parameter int CODE_W   = 8,
  parameter int DLY_W    = 4,
  parameter int SYNC_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              gbl_en_pin,
  input  logic              gbl_en_bit,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_mode,
  input  logic [CODE_W-1:0] cfg_div,
  input  logic [DLY_W-1:0]  cfg_dly,
  output logic              clk_out,
  output logic [1:0]        mode_o,
  output logic [DLY_W-1:0]  dly_tag
);

  localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

  logic              en_q;
  logic [1:0]        mode_q;
  logic [CODE_W-1:0] code_q;
  logic [DLY_W-1:0]  dly_q;

  logic [SYNC_LAT-1:0] sync_pipe;
  logic                held_q;
  logic                phase_q;
  logic [CODE_W-1:0]   cnt_q;

  logic              sync_ok;
  logic              en_all;
  logic [CODE_W-1:0] half_len;
  logic [CODE_W-1:0] last_cnt;

  assign sync_ok  = sync_pipe[SYNC_LAT-1];
  assign en_all   = en_q & gbl_en_bit & gbl_en_pin;
  assign half_len = (code_q == '0) ? CODE_ONE : code_q;
  assign last_cnt = half_len - CODE_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 2'd0;
      code_q <= CODE_ONE;
      dly_q  <= '0;
    end else if (cfg_wr) begin
      en_q   <= cfg_en;
      mode_q <= cfg_mode;
      code_q <= cfg_div;
      dly_q  <= cfg_dly;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_pipe <= '1;
      held_q    <= 1'b0;
      phase_q   <= 1'b0;
      cnt_q     <= '0;
    end else begin
      sync_pipe <= {sync_pipe[SYNC_LAT-2:0], sync_n};
      held_q    <= ~sync_ok;
      if (!sync_ok) begin
        phase_q <= 1'b0;
        cnt_q   <= '0;
      end else if (held_q) begin
        phase_q <= 1'b1;
        cnt_q   <= '0;
      end else if (cnt_q >= last_cnt) begin
        phase_q <= ~phase_q;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + CODE_ONE;
      end
    end
  end

  assign clk_out = en_all & (mode_q[0] ? phase_q : clk);
  assign mode_o  = mode_q;
  assign dly_tag = mode_q[1] ? dly_q : '0;

endmodule

module clk_chan_div_chk #(
  parameter int CODE_W = 8,
  parameter int DLY_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_n,
  input logic              gbl_en_pin,
  input logic              gbl_en_bit,
  input logic              cfg_wr,
  input logic [1:0]        cfg_mode,
  input logic              en_all,
  input logic [CODE_W-1:0] code_q,
  input logic              clk_out,
  input logic [1:0]        mode_o,
  input logic [DLY_W-1:0]  dly_tag
);

  logic [3:0] since_rst, sync_lo, sync_hi, cfg_quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      sync_lo   <= '0;
      sync_hi   <= '0;
      cfg_quiet <= '0;
    end else begin
      if (since_rst != 4'hf) since_rst <= since_rst + 4'd1;
      sync_lo   <= sync_n ? 4'd0 : ((sync_lo == 4'hf) ? sync_lo : sync_lo + 4'd1);
      sync_hi   <= !sync_n ? 4'd0 : ((sync_hi == 4'hf) ? sync_hi : sync_hi + 4'd1);
      cfg_quiet <= cfg_wr ? 4'd0 : ((cfg_quiet == 4'hf) ? cfg_quiet : cfg_quiet + 4'd1);
    end
  end

  // R1
  rst_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode_o == 2'd0 && dly_tag == '0 && !clk_out));

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (mode_o == $past(cfg_mode)));

  // R8
  gbl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gbl_en_pin || !gbl_en_bit) |-> !clk_out);

  // R5
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd6 && sync_lo >= 4'd5 && mode_o[0]) |-> !clk_out);

  // R3
  div2_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd3 && sync_hi >= 4'd6 && cfg_quiet >= 4'd2 && mode_o[0]
     && code_q <= CODE_W'(1) && en_all && $past(en_all))
    |-> (clk_out != $past(clk_out)));

endmodule

bind clk_chan_div clk_chan_div_chk #(.CODE_W(CODE_W), .DLY_W(DLY_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .gbl_en_pin(gbl_en_pin),
  .gbl_en_bit(gbl_en_bit), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
  .en_all(en_all), .code_q(code_q), .clk_out(clk_out), .mode_o(mode_o),
  .dly_tag(dly_tag)
);

// File: tb/clk_chan_div_tb.sv
`timescale 1ns/1ps
module clk_chan_div_tb_top;
  localparam int NCH = 4;

  typedef struct {
    int    cyc;
    int    ch;
    int    kind;
    int    exp;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic gpin = 1'b1;
  logic gbit = 1'b1;
  logic       cwr   [NCH];
  logic       cen   [NCH];
  logic [1:0] cmode [NCH];
  logic [7:0] cdiv  [NCH];
  logic [3:0] cdly  [NCH];
  logic       co    [NCH];
  logic [1:0] mo    [NCH];
  logic [3:0] tg    [NCH];

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  item_t sb[$];

  always #2 clk = ~clk;

  for (genvar g = 0; g < NCH; g++) begin : ch
    clk_chan_div dut_i (
      .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .gbl_en_pin(gpin),
      .gbl_en_bit(gbit), .cfg_wr(cwr[g]), .cfg_en(cen[g]), .cfg_mode(cmode[g]),
      .cfg_div(cdiv[g]), .cfg_dly(cdly[g]), .clk_out(co[g]), .mode_o(mo[g]),
      .dly_tag(tg[g])
    );
  end

  task automatic expect_at(int c, int chn, int kind, int e, string req);
    item_t it;
    int i;
    it = '{c, chn, kind, e, req};
    i = 0;
    while (i < sb.size() && sb[i].cyc <= c) i++;
    sb.insert(i, it);
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      for (int k = 0; k < NCH; k++) cwr[k] = 1'b0;
    end
  endtask

  task automatic cfg(int chn, bit en, int mode, int dv, int dl);
    cwr[chn] = 1'b1;
    cen[chn] = en;
    cmode[chn] = 2'(mode);
    cdiv[chn] = 8'(dv);
    cdly[chn] = 4'(dl);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin : monitor
    item_t it;
    int act;
    #1;
    cyc++;
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      it = sb.pop_front();
      case (it.kind)
        0: act = int'(co[it.ch]);
        1: act = int'(mo[it.ch]);
        default: act = int'(tg[it.ch]);
      endcase
      checks++;
      if (it.cyc != cyc || act != it.exp) begin
        failures++;
        $display("FAIL %s ch%0d kind%0d cycle %0d actual=%0d expected=%0d",
                 it.req, it.ch, it.kind, it.cyc, act, it.exp);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin : driver
    int c, d;
    for (int k = 0; k < NCH; k++) begin
      cwr[k] = 1'b0; cen[k] = 1'b0; cmode[k] = 2'd0; cdiv[k] = 8'd1; cdly[k] = 4'd0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state of every lane
    for (int k = 0; k < NCH; k++) begin
      expect_at(cyc + 1, k, 0, 0, "R1");
      expect_at(cyc + 1, k, 1, 0, "R1");
      expect_at(cyc + 1, k, 2, 0, "R1");
    end
    rst_n = 1'b1;
    tick(2);

    // R2 / R9: configuration load
    c = cyc;
    cfg(0, 1, 0, 1, 3);
    cfg(1, 1, 1, 1, 9);
    cfg(2, 1, 1, 2, 0);
    cfg(3, 1, 3, 3, 5);
    expect_at(c + 1, 0, 1, 0, "R2");
    expect_at(c + 1, 1, 1, 1, "R2");
    expect_at(c + 1, 3, 1, 3, "R2");
    expect_at(c + 1, 0, 2, 0, "R9");
    expect_at(c + 1, 1, 2, 0, "R9");
    expect_at(c + 1, 3, 2, 5, "R9");
    tick(3);

    // R5 / R7: synchronization hold, bypass lane unaffected
    c = cyc;
    sync_n = 1'b0;
    for (int t = 5; t <= 12; t++) begin
      for (int k = 1; k < NCH; k++) expect_at(c + t, k, 0, 0, "R5");
      expect_at(c + t, 0, 0, 1, "R7");
    end
    tick(10);

    // R6 / R3: common release and ratio patterns
    d = cyc;
    sync_n = 1'b1;
    for (int k = 1; k < NCH; k++) expect_at(d + 4, k, 0, 0, "R6");
    for (int k = 1; k < NCH; k++) expect_at(d + 5, k, 0, 1, "R6");
    for (int t = 6; t <= 16; t++) begin
      expect_at(d + t, 1, 0, ((t - 5) % 2) == 0 ? 1 : 0, "R3");
      expect_at(d + t, 2, 0, ((t - 5) % 4) < 2 ? 1 : 0, "R3");
      expect_at(d + t, 3, 0, ((t - 5) % 6) < 3 ? 1 : 0, "R3");
    end
    tick(20);

    // R8: enable gating
    c = cyc;
    gpin = 1'b0;
    for (int k = 0; k < NCH; k++) expect_at(c + 1, k, 0, 0, "R8");
    tick(2);
    c = cyc;
    gpin = 1'b1;
    gbit = 1'b0;
    for (int k = 0; k < NCH; k++) expect_at(c + 1, k, 0, 0, "R8");
    tick(2);
    c = cyc;
    gbit = 1'b1;
    cfg(0, 0, 0, 1, 0);
    expect_at(c + 1, 0, 0, 0, "R8");
    tick(3);

    // R4 / R7 / R9: code 0 fallback, delayed path ignores sync
    c = cyc;
    cfg(0, 1, 2, 1, 7);
    cfg(3, 1, 3, 0, 5);
    expect_at(c + 1, 0, 1, 2, "R2");
    expect_at(c + 1, 0, 2, 7, "R9");
    expect_at(c + 1, 0, 0, 1, "R7");
    tick(3);
    c = cyc;
    sync_n = 1'b0;
    for (int t = 5; t <= 7; t++) expect_at(c + t, 3, 0, 0, "R5");
    for (int t = 5; t <= 11; t++) expect_at(c + t, 0, 0, 1, "R7");
    expect_at(c + 8, 1, 0, 1, "R6");
    expect_at(c + 8, 2, 0, 1, "R6");
    expect_at(c + 8, 3, 0, 1, "R6");
    expect_at(c + 9, 3, 0, 0, "R4");
    expect_at(c + 10, 3, 0, 1, "R4");
    expect_at(c + 11, 3, 0, 0, "R4");
    expect_at(c + 10, 2, 0, 0, "R3");
    tick(3);
    sync_n = 1'b1;
    tick(20);

    if (sb.size() != 0) begin
      failures++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
    end
    report();
    $finish;
  end
endmodule